// File: doc/BRIEF.md
# Charge Bar Display Driver

This block turns a battery's available-charge count into a five-segment LED bar. The bar uses a fixed scale: each segment is worth one fifth of the programmed full capacity. A segment stays dark if the learned capacity cannot reach its threshold. When the battery is cold, the displayed fraction is reduced, but the charge count supplied to the block is not changed.

The segments are split into two interleaved banks that are time multiplexed inside a ten-phase frame. A single common-enable line gates the LEDs, and it is driven only while the display is on. The display turns on in three ways:
- for a fixed window after the push-button input falls;
- while fast charge or fast discharge activity is present, if automatic mode is selected;
- for a hold window after fast discharge ends, also in automatic mode.

Segment 1 blinks when the battery is low. A test override replaces the computed pattern with register bits. All timing comes from one prescaler whose ratios are parameters. Inputs are assumed to be already synchronous to `clk`.

Top module: `chg_bar_display`

## Requirements
- R1: Segment k (k = 1..5, driven on `seg_n[k-1]`) is lit only when 5 × effective charge ≥ k × `prog_full` and 5 × `full_ref` ≥ k × `prog_full`. No segment of bits 4..1 ever lights while the charge is zero.
- R2: The effective charge depends on `temp_code`:
  - codes 4 and above use `charge`;
  - codes 2 and 3 use floor(3 × `charge` / 4);
  - codes 0 and 1 use floor(`charge` / 2).
- R3: Each frame has ten phases of `MUX_DIV` clocks each.
  - Segments 1, 3 and 5 (bits 0, 2, 4) may light only in phases 0–2.
  - Segments 2 and 4 (bits 1, 3) may light only in phases 5–7.
  - `com_en` is high in exactly those six phases while the display is on, so each bank gets 30 % duty.
  - The two banks are never lit in the same cycle.
- R4: When `edv_flag` is 1 or 10 × `charge` < `prog_full`, segment 1 follows a blink state instead of the bar. The blink state toggles every `BLINK_TICKS` phases.
- R5: A high-to-low transition of `disp_btn` turns the display on for `PUSH_SEC` × `SEC_TICKS` phases. Holding the button low does not extend this, and a rising edge does nothing.
- R6: With `auto_mode` = 1:
  - `fast_chg` or `fast_dis` keeps the display on;
  - after `fast_dis` drops, the display stays on for a further `HOLD_SEC` × `SEC_TICKS` phases.
  
  With `auto_mode` = 0, the activity inputs have no effect.
- R7: While `ovr_en` = 1, the following cycle has `seg_n` = ~`ovr_seg` with no multiplexing, and `com_en` = 1.
- R8: While `init_busy` = 1, `com_en` is 0. Segments are dark unless the override is active.
- R9: During reset, `seg_n` is 5'b11111 and `com_en` is 0. All outputs are registered and change one clock after their inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| init_busy | input | 1 | Initialisation in progress; common line held off |
| charge | input | CHG_W | Available charge count |
| full_ref | input | CHG_W | Learned full capacity |
| prog_full | input | CHG_W | Programmed full capacity (bar scale) |
| temp_code | input | 4 | Temperature band code, 10 °C steps, 0 = coldest |
| edv_flag | input | 1 | End-of-discharge flag |
| fast_chg | input | 1 | Fast charge activity |
| fast_dis | input | 1 | Fast discharge activity |
| auto_mode | input | 1 | Display control in automatic setting |
| disp_btn | input | 1 | Push-button, active low |
| ovr_en | input | 1 | Test override enable |
| ovr_seg | input | 5 | Override segment states, bit i = segment i+1 |
| seg_n | output | 5 | Active-low segment enables |
| com_en | output | 1 | Common LED enable |

## Verification
Some properties are checked on every cycle:
- the two banks are never lit together;
- `com_en` stays low after an initialisation cycle;
- segments are dark whenever the common line is off;
- the override pattern appears one cycle after it is requested;
- the upper four segments stay dark for a zero charge.

Other behaviour only the bench scenarios can show:
- the bar level for each charge, capacity and temperature band;
- the exact 30 % duty of each bank;
- the blink of segment 1;
- the lengths of the push-button and discharge-hold windows, and the point where each window ends.

// File: rtl/bar_disp_pkg.sv
package bar_disp_pkg;
  localparam int SEG_N    = 5;
  localparam int FRAME_PH = 10;
  localparam int PH_W     = 4;
  localparam int A_FIRST  = 0;
  localparam int A_LAST   = 2;
  localparam int B_FIRST  = 5;
  localparam int B_LAST   = 7;
  localparam logic [SEG_N-1:0] BANK_A_MASK = 5'b10101;
  localparam logic [SEG_N-1:0] BANK_B_MASK = 5'b01010;

  typedef enum logic [1:0] {TEMP_COLD, TEMP_COOL, TEMP_WARM} temp_band_t;

  function automatic temp_band_t band_of(input logic [3:0] code);
    if (code <= 4'd1)      return TEMP_COLD;
    else if (code <= 4'd3) return TEMP_COOL;
    else                   return TEMP_WARM;
  endfunction
endpackage

// File: rtl/bar_tick_gen.sv
module bar_tick_gen
  import bar_disp_pkg::*;
#(
  parameter int MUX_DIV     = 39062,
  parameter int BLINK_TICKS = 400
) (
  input  logic            clk,
  input  logic            rst_n,
  output logic            step,
  output logic [PH_W-1:0] phase,
  output logic            blink
);
  localparam int DIV_W = (MUX_DIV > 1) ? $clog2(MUX_DIV) : 1;
  localparam int BLK_W = (BLINK_TICKS > 1) ? $clog2(BLINK_TICKS) : 1;

  logic [DIV_W-1:0] div_q, div_d;
  logic [PH_W-1:0]  ph_q, ph_d;
  logic [BLK_W-1:0] blk_q, blk_d;
  logic             blink_q, blink_d;
  logic             step_w;

  assign step_w = (div_q == DIV_W'(MUX_DIV - 1));

  always_comb begin
    div_d   = step_w ? '0 : div_q + 1'b1;
    ph_d    = ph_q;
    blk_d   = blk_q;
    blink_d = blink_q;
    if (step_w) begin
      ph_d = (ph_q == PH_W'(FRAME_PH - 1)) ? '0 : ph_q + 1'b1;
      if (blk_q == BLK_W'(BLINK_TICKS - 1)) begin
        blk_d   = '0;
        blink_d = ~blink_q;
      end else begin
        blk_d = blk_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q   <= '0;
      ph_q    <= '0;
      blk_q   <= '0;
      blink_q <= 1'b0;
    end else begin
      div_q   <= div_d;
      ph_q    <= ph_d;
      blk_q   <= blk_d;
      blink_q <= blink_d;
    end
  end

  assign step  = step_w;
  assign phase = ph_q;
  assign blink = blink_q;
endmodule

// File: rtl/bar_level_calc.sv
module bar_level_calc
  import bar_disp_pkg::*;
#(
  parameter int CHG_W = 16
) (
  input  logic [CHG_W-1:0] charge,
  input  logic [CHG_W-1:0] full_ref,
  input  logic [CHG_W-1:0] prog_full,
  input  logic [3:0]       temp_code,
  input  logic             edv_flag,
  output logic [SEG_N-1:0] level,
  output logic             low_batt
);
  localparam int PW = CHG_W + 4;

  logic [PW-1:0] c_ext, c_x3, c_x10, eff, eff_x5, cap_x5, pf_ext;
  temp_band_t    band;

  assign c_ext  = PW'(charge);
  assign pf_ext = PW'(prog_full);
  assign c_x3   = c_ext + (c_ext << 1);
  assign c_x10  = (c_ext << 3) + (c_ext << 1);
  assign band   = band_of(temp_code);

  always_comb begin
    unique case (band)
      TEMP_COLD: eff = c_ext >> 1;
      TEMP_COOL: eff = c_x3 >> 2;
      default:   eff = c_ext;
    endcase
  end

  assign eff_x5 = eff + (eff << 2);
  assign cap_x5 = PW'(full_ref) + (PW'(full_ref) << 2);

  for (genvar k = 1; k <= SEG_N; k++) begin : g_thr
    logic [PW-1:0] thr;
    assign thr        = pf_ext * PW'(k);
    assign level[k-1] = (eff_x5 >= thr) && (cap_x5 >= thr);
  end

  assign low_batt = edv_flag || (c_x10 < pf_ext);
endmodule

// File: rtl/bar_on_timer.sv
module bar_on_timer #(
  parameter int SEC_TICKS = 3200,
  parameter int PUSH_SEC  = 4,
  parameter int HOLD_SEC  = 10
) (
  input  logic clk,
  input  logic rst_n,
  input  logic step,
  input  logic disp_btn,
  input  logic auto_mode,
  input  logic fast_chg,
  input  logic fast_dis,
  output logic disp_on
);
  localparam int PUSH_TICKS = PUSH_SEC * SEC_TICKS;
  localparam int HOLD_TICKS = HOLD_SEC * SEC_TICKS;
  localparam int MAX_TICKS  = (PUSH_TICKS > HOLD_TICKS) ? PUSH_TICKS : HOLD_TICKS;
  localparam int TW         = $clog2(MAX_TICKS + 1);

  logic          btn_q;
  logic [TW-1:0] push_q, push_d, hold_q, hold_d;

  always_comb begin
    push_d = push_q;
    if (btn_q && !disp_btn)            push_d = TW'(PUSH_TICKS);
    else if (step && push_q != '0)     push_d = push_q - 1'b1;

    hold_d = hold_q;
    if (auto_mode && fast_dis)         hold_d = TW'(HOLD_TICKS);
    else if (step && hold_q != '0)     hold_d = hold_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      btn_q  <= 1'b1;
      push_q <= '0;
      hold_q <= '0;
    end else begin
      btn_q  <= disp_btn;
      push_q <= push_d;
      hold_q <= hold_d;
    end
  end

  assign disp_on = (push_q != '0) ||
                   (auto_mode && (fast_chg || fast_dis || hold_q != '0));
endmodule

// File: rtl/chg_bar_display.sv
module chg_bar_display
  import bar_disp_pkg::*;
#(
  parameter int CHG_W       = 16,
  parameter int MUX_DIV     = 39062,
  parameter int BLINK_TICKS = 400,
  parameter int SEC_TICKS   = 3200,
  parameter int PUSH_SEC    = 4,
  parameter int HOLD_SEC    = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             init_busy,
  input  logic [CHG_W-1:0] charge,
  input  logic [CHG_W-1:0] full_ref,
  input  logic [CHG_W-1:0] prog_full,
  input  logic [3:0]       temp_code,
  input  logic             edv_flag,
  input  logic             fast_chg,
  input  logic             fast_dis,
  input  logic             auto_mode,
  input  logic             disp_btn,
  input  logic             ovr_en,
  input  logic [4:0]       ovr_seg,
  output logic [4:0]       seg_n,
  output logic             com_en
);
  logic            step, blink, disp_on, low_batt;
  logic [PH_W-1:0] phase;
  logic [SEG_N-1:0] level, lit;
  logic            bank_a, bank_b;
  logic [SEG_N-1:0] seg_n_q, seg_n_d;
  logic            com_q, com_d;

  bar_tick_gen #(.MUX_DIV(MUX_DIV), .BLINK_TICKS(BLINK_TICKS)) u_tick (
    .clk(clk), .rst_n(rst_n), .step(step), .phase(phase), .blink(blink));

  bar_level_calc #(.CHG_W(CHG_W)) u_level (
    .charge(charge), .full_ref(full_ref), .prog_full(prog_full),
    .temp_code(temp_code), .edv_flag(edv_flag),
    .level(level), .low_batt(low_batt));

  bar_on_timer #(.SEC_TICKS(SEC_TICKS), .PUSH_SEC(PUSH_SEC), .HOLD_SEC(HOLD_SEC)) u_timer (
    .clk(clk), .rst_n(rst_n), .step(step), .disp_btn(disp_btn),
    .auto_mode(auto_mode), .fast_chg(fast_chg), .fast_dis(fast_dis),
    .disp_on(disp_on));

  assign bank_a = (phase >= PH_W'(A_FIRST)) && (phase <= PH_W'(A_LAST));
  assign bank_b = (phase >= PH_W'(B_FIRST)) && (phase <= PH_W'(B_LAST));

  always_comb begin
    lit    = level;
    lit[0] = low_batt ? blink : level[0];
  end

  always_comb begin
    seg_n_d = '1;
    com_d   = 1'b0;
    if (ovr_en) begin
      seg_n_d = ~ovr_seg;
      com_d   = !init_busy;
    end else if (disp_on && !init_busy && (bank_a || bank_b)) begin
      com_d   = 1'b1;
      seg_n_d = ~(lit & (bank_a ? BANK_A_MASK : BANK_B_MASK));
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seg_n_q <= '1;
      com_q   <= 1'b0;
    end else begin
      seg_n_q <= seg_n_d;
      com_q   <= com_d;
    end
  end

  assign seg_n  = seg_n_q;
  assign com_en = com_q;
endmodule

// File: rtl/bar_disp_chk.sv
module bar_disp_chk #(
  parameter int CHG_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             init_busy,
  input logic [CHG_W-1:0] charge,
  input logic             ovr_en,
  input logic [4:0]       ovr_seg,
  input logic [4:0]       seg_n,
  input logic             com_en
);
  logic a_lit, b_lit;
  assign a_lit = !seg_n[0] || !seg_n[2] || !seg_n[4];
  assign b_lit = !seg_n[1] || !seg_n[3];

  assert_bank_excl_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(ovr_en) |-> !(a_lit && b_lit));

  assert_init_dark_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $past(init_busy) |-> !com_en);

  assert_off_dark_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!com_en && !$past(ovr_en)) |-> (seg_n == 5'b11111));

  assert_override_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(ovr_en) && !$past(init_busy)) |-> (com_en && seg_n == ~$past(ovr_seg)));

  assert_empty_dark_R1: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(charge) == '0 && !$past(ovr_en)) |-> (seg_n[4:1] == 4'b1111));
endmodule

bind chg_bar_display bar_disp_chk #(.CHG_W(CHG_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .init_busy(init_busy), .charge(charge),
  .ovr_en(ovr_en), .ovr_seg(ovr_seg), .seg_n(seg_n), .com_en(com_en));

// File: tb/chg_bar_display_tb.sv
`timescale 1ns/1ps
module chg_bar_display_tb;
  localparam int CHG_W = 16;
  localparam int MUX_DIV = 2;
  localparam int BLINK_TICKS = 4;
  localparam int SEC_TICKS = 20;

  logic clk = 1'b0;
  logic rst_n, init_busy, edv_flag, fast_chg, fast_dis, auto_mode, disp_btn, ovr_en;
  logic [CHG_W-1:0] charge, full_ref, prog_full;
  logic [3:0] temp_code;
  logic [4:0] ovr_seg, seg_n;
  logic com_en;

  int total = 0;
  int bad = 0;
  int cyc = 0;

  always #4 clk = ~clk;

  chg_bar_display #(.CHG_W(CHG_W), .MUX_DIV(MUX_DIV), .BLINK_TICKS(BLINK_TICKS),
                    .SEC_TICKS(SEC_TICKS), .PUSH_SEC(4), .HOLD_SEC(10)) u_dut (
    .clk(clk), .rst_n(rst_n), .init_busy(init_busy), .charge(charge),
    .full_ref(full_ref), .prog_full(prog_full), .temp_code(temp_code),
    .edv_flag(edv_flag), .fast_chg(fast_chg), .fast_dis(fast_dis),
    .auto_mode(auto_mode), .disp_btn(disp_btn), .ovr_en(ovr_en),
    .ovr_seg(ovr_seg), .seg_n(seg_n), .com_en(com_en));

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      bad = bad + 1;
      total = total + 1;
      $display("FAIL watchdog: actual=%0d expected<150000 cycles", cyc);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    total = total + 1;
    if (!ok) begin
      bad = bad + 1;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // Observe n negedges: OR of lit segments, com count, overlap, bank counts,
  // and segment 1 on/off among samples with segment 3 lit.
  task automatic watch(input int n, output logic [4:0] m, output int com_c,
                       output int both, output int a_c, output int b_c,
                       output int s1_on, output int s1_off);
    m = '0; com_c = 0; both = 0; a_c = 0; b_c = 0; s1_on = 0; s1_off = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      m = m | ~seg_n;
      if (com_en) com_c++;
      if ((~seg_n & 5'b10101) != 0 && (~seg_n & 5'b01010) != 0) both++;
      if (!seg_n[2]) begin
        a_c++;
        if (!seg_n[0]) s1_on++; else s1_off++;
      end
      if (!seg_n[1]) b_c++;
    end
  endtask

  function automatic logic [4:0] exp_mask(input int c, input int pf, input int lmd,
                                          input int tc);
    int eff;
    logic [4:0] r;
    if (tc <= 1)      eff = c / 2;
    else if (tc <= 3) eff = (3 * c) / 4;
    else              eff = c;
    for (int k = 1; k <= 5; k++)
      r[k-1] = (5 * eff >= k * pf) && (5 * lmd >= k * pf);
    return r;
  endfunction

  initial begin
    logic [4:0] m;
    int com_c, both, a_c, b_c, s1_on, s1_off;
    int tcs[3] = '{0, 2, 6};
    int lmds[2] = '{1000, 700};
    int ovl;

    rst_n = 1'b0; init_busy = 1'b0; edv_flag = 1'b0; fast_chg = 1'b0;
    fast_dis = 1'b0; auto_mode = 1'b0; disp_btn = 1'b1; ovr_en = 1'b0;
    ovr_seg = '0; charge = 16'd1000; full_ref = 16'd1000; prog_full = 16'd1000;
    temp_code = 4'd6;
    repeat (4) @(negedge clk);
    check(seg_n == 5'b11111 && com_en == 1'b0, "R9", "reset outputs",
          {seg_n, com_en}, 6'b111110);
    rst_n = 1'b1;

    // R8: init holds common off even with activity
    init_busy = 1'b1; auto_mode = 1'b1; fast_chg = 1'b1;
    watch(40, m, com_c, both, a_c, b_c, s1_on, s1_off);
    check(com_c == 0 && m == 0, "R8", "init keeps display dark", com_c, 0);
    init_busy = 1'b0;

    // R1/R2 sweep over charge, learned capacity and temperature band
    ovl = 0;
    foreach (lmds[li]) begin
      foreach (tcs[ti]) begin
        for (int c = 100; c <= 1100; c += 50) begin
          @(negedge clk);
          charge = 16'(c); full_ref = 16'(lmds[li]); temp_code = 4'(tcs[ti]);
          repeat (2) @(negedge clk);
          watch(24, m, com_c, both, a_c, b_c, s1_on, s1_off);
          ovl += both;
          check(m == exp_mask(c, 1000, lmds[li], tcs[ti]),
                (tcs[ti] == 6) ? "R1" : "R2", "bar mask", m,
                exp_mask(c, 1000, lmds[li], tcs[ti]));
        end
      end
    end
    check(ovl == 0, "R3", "bank overlap during sweep", ovl, 0);

    // R3 duty: 10 frames of 20 clocks
    charge = 16'd1000; full_ref = 16'd1000; temp_code = 4'd6;
    repeat (3) @(negedge clk);
    watch(200, m, com_c, both, a_c, b_c, s1_on, s1_off);
    check(com_c == 120, "R3", "common on cycles", com_c, 120);
    check(a_c == 60, "R3", "bank A cycles", a_c, 60);
    check(b_c == 60, "R3", "bank B cycles", b_c, 60);
    check(both == 0, "R3", "banks overlap", both, 0);

    // R4 blink with end-of-discharge flag at full charge
    edv_flag = 1'b1;
    repeat (2) @(negedge clk);
    watch(400, m, com_c, both, a_c, b_c, s1_on, s1_off);
    check(s1_on > 0, "R4", "seg1 on during bank A", s1_on, 1);
    check(s1_off > 0, "R4", "seg1 off during bank A", s1_off, 1);
    edv_flag = 1'b0;
    charge = 16'd90;
    repeat (2) @(negedge clk);
    watch(400, m, com_c, both, a_c, b_c, s1_on, s1_off);
    check(m == 5'b00001, "R4", "low charge blinks seg1 only", m, 1);
    charge = 16'd100;
    repeat (2) @(negedge clk);
    watch(200, m, com_c, both, a_c, b_c, s1_on, s1_off);
    check(m == 5'b00000, "R4", "10 percent boundary no blink", m, 0);

    // R6: activity off, then activity ignored outside automatic mode
    charge = 16'd1000; fast_chg = 1'b0;
    repeat (2) @(negedge clk);
    watch(40, m, com_c, both, a_c, b_c, s1_on, s1_off);
    check(com_c == 0, "R6", "no activity display off", com_c, 0);
    auto_mode = 1'b0; fast_chg = 1'b1; fast_dis = 1'b1;
    watch(60, m, com_c, both, a_c, b_c, s1_on, s1_off);
    check(com_c == 0, "R6", "activity ignored when not auto", com_c, 0);
    fast_chg = 1'b0; fast_dis = 1'b0;
    repeat (2) @(negedge clk);

    // R6 discharge hold: 200 phases = 400 clocks
    auto_mode = 1'b1; fast_dis = 1'b1;
    watch(30, m, com_c, both, a_c, b_c, s1_on, s1_off);
    check(com_c > 0, "R6", "fast discharge display on", com_c, 1);
    fast_dis = 1'b0;
    repeat (365) @(negedge clk);
    watch(20, m, com_c, both, a_c, b_c, s1_on, s1_off);
    check(com_c > 0, "R6", "still on near end of hold", com_c, 1);
    repeat (34) @(negedge clk);
    watch(40, m, com_c, both, a_c, b_c, s1_on, s1_off);
    check(com_c == 0, "R6", "off after hold", com_c, 0);

    // R5 push window: 80 phases = 160 clocks
    auto_mode = 1'b0;
    disp_btn = 1'b0;
    watch(20, m, com_c, both, a_c, b_c, s1_on, s1_off);
    check(com_c > 0, "R5", "on after button falls", com_c, 1);
    repeat (110) @(negedge clk);
    watch(20, m, com_c, both, a_c, b_c, s1_on, s1_off);
    check(com_c > 0, "R5", "on near end of window", com_c, 1);
    repeat (19) @(negedge clk);
    watch(40, m, com_c, both, a_c, b_c, s1_on, s1_off);
    check(com_c == 0, "R5", "off after window with button held", com_c, 0);
    disp_btn = 1'b1;
    watch(40, m, com_c, both, a_c, b_c, s1_on, s1_off);
    check(com_c == 0, "R5", "rising edge ignored", com_c, 0);

    // R7 override with display otherwise off
    ovr_en = 1'b1; ovr_seg = 5'b10101;
    repeat (2) @(negedge clk);
    begin
      int good = 0;
      for (int i = 0; i < 30; i++) begin
        @(negedge clk);
        if (seg_n == 5'b01010 && com_en) good++;
      end
      check(good == 30, "R7", "override pattern steady", good, 30);
    end
    ovr_seg = 5'b11111;
    repeat (2) @(negedge clk);
    check(seg_n == 5'b00000 && com_en, "R7", "override all on", seg_n, 0);
    init_busy = 1'b1;
    repeat (2) @(negedge clk);
    check(!com_en && seg_n == 5'b00000, "R8", "init with override", com_en, 0);
    init_busy = 1'b0; ovr_en = 1'b0;
    repeat (2) @(negedge clk);
    check(seg_n == 5'b11111 && !com_en, "R7", "override released dark", seg_n, 31);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule